// File: doc/BRIEF.md
# Indexed Voice-Control Register Port

This block is the control-register file of an eight-voice sound generator. A host reaches it through two ports. A write to the select port latches a 7-bit register index. Later writes and reads on the data port go to the register that the index names. Data-port reads are combinational and follow the latched index at once.

The upper three index bits name a voice. Low nibbles 0 to 9 are that voice's ten registers. Nibbles 8 and 9 are read-only views of the voice's live envelope level and output sample, which come in on input buses. Every other index is a plain byte of storage, apart from four control registers whose writes have side effects:

- Key-on ($4C) emits a one-cycle start pulse per voice.
- Key-off ($5C) emits a one-cycle release pulse per voice.
- Flags ($6C) drives a global mute and suppresses key-on while its soft-reset bit is set.
- End flags ($7C) collect sticky per-voice end-of-sample flags.

The sample decoder, the envelope engines and the mixer sit outside and use the pulses and the mute.

Top module: `vreg_port`

## Requirements
- R1: A cycle with `sel_we` high latches `sel_data[6:0]` as the current index, and bit 7 is ignored. Data-port writes and reads use that index from the next cycle on. A write to a storage index reads back the written byte.
- R2: After reset, every storage index and the end-flag register read $00, the flag register ($6C) reads $E0, `mute_all` is high, and both pulse buses are zero.
- R3: A data write to $4C makes `kon_pulse` equal the written byte for exactly the following cycle. If the flag register's bit 7 (soft reset) is set when the write occurs, the pulse is all zero.
- R4: A data write to $5C makes `koff_pulse` equal the written byte for exactly the following cycle, whatever the flag register holds.
- R5: `end_strobe[n]` sets bit n of the end-flag register ($7C). The bit stays set until it is cleared by R6 or R7.
- R6: Any data write to $7C clears all eight end-flag bits, whatever the data. The clear takes priority over a strobe in the same cycle.
- R7: A key-on write that is not suppressed clears the end-flag bit of each voice it starts. The clear takes priority over a strobe for that voice in the same cycle. A suppressed key-on leaves the end flags unchanged.
- R8: `mute_all` is high while flag bit 7 (soft reset) or bit 6 (mute) is set, and low otherwise. It follows a flag-register write from the next cycle.
- R9: Index {v,8} reads `env_level` byte v, and index {v,9} reads `wave_level` byte v. Writes to these indices change nothing that can be read.
- R10: When `sel_we` and `dat_we` are high in the same cycle, the data write goes to the previously latched index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Latch a new register index |
| sel_data | input | 8 | Index value; bit 7 ignored |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 8 | Data-port write value |
| dat_rdata | output | 8 | Selected register contents |
| env_level | input | 64 | Per-voice envelope level, byte v for voice v |
| wave_level | input | 64 | Per-voice output sample, byte v for voice v |
| end_strobe | input | 8 | Per-voice end-of-sample strobes |
| kon_pulse | output | 8 | Per-voice key-on pulses |
| koff_pulse | output | 8 | Per-voice key-off pulses |
| mute_all | output | 1 | Global mute |

## Verification
Directed sequences cover each side effect on its own:
- Key-on with soft reset set and with it clear, which separates gating from pulse generation.
- End strobes, followed by an end-flag write in the same cycle as a strobe, which shows whether the clear wins.
- A key-on that coincides with strobes on overlapping and disjoint voices, which exposes the per-voice clear priority.
- A simultaneous select and data write, which reveals whether the write uses the old index.

A long random phase then mixes writes, biased towards the four control indices, with random strobes and changing envelope and sample inputs. A behavioural model checks every output on every clock, which catches crossed interactions that the directed cases miss.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
   localparam int IDX_W = 7;

   localparam logic [IDX_W-1:0] KON_IDX  = 7'h4C;
   localparam logic [IDX_W-1:0] KOFF_IDX = 7'h5C;
   localparam logic [IDX_W-1:0] FLG_IDX  = 7'h6C;
   localparam logic [IDX_W-1:0] ENDF_IDX = 7'h7C;

   localparam logic [3:0] NIB_ENV  = 4'h8;
   localparam logic [3:0] NIB_WAVE = 4'h9;

   localparam int FLG_SRST_BIT = 7;
   localparam int FLG_MUTE_BIT = 6;
   localparam logic [7:0] FLG_RST_VAL = 8'hE0;

   typedef enum logic [2:0] {
      CLS_PLAIN = 3'd0,
      CLS_ENV   = 3'd1,
      CLS_WAVE  = 3'd2,
      CLS_FLAG  = 3'd3,
      CLS_ENDF  = 3'd4
   } vreg_cls_e;

   function automatic vreg_cls_e vreg_classify(input logic [IDX_W-1:0] idx);
      vreg_cls_e c;
      if (idx[3:0] == NIB_ENV)       c = CLS_ENV;
      else if (idx[3:0] == NIB_WAVE) c = CLS_WAVE;
      else if (idx == FLG_IDX)       c = CLS_FLAG;
      else if (idx == ENDF_IDX)      c = CLS_ENDF;
      else                           c = CLS_PLAIN;
      return c;
   endfunction
endpackage

// File: rtl/vreg_idx_latch.sv
module vreg_idx_latch
   import vreg_pkg::*;
#(
   parameter int IN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IN_W-1:0]  din,
   output logic [IDX_W-1:0] idx
);
   if (IN_W <= IDX_W) begin : g_bad_w
      $error("vreg_idx_latch: IN_W must exceed IDX_W");
   end

   logic unused_hi;
   assign unused_hi = ^din[IN_W-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= '0;
      else if (load) idx <= din[IDX_W-1:0];
   end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank
   import vreg_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DW-1:0] cell_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      logic hit;
      assign hit = we && (idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cell_q[e] <= '0;
         else if (hit) cell_q[e] <= wdata;
      end
   end

   assign rdata = cell_q[idx];
endmodule

// File: rtl/vreg_side.sv
module vreg_side
   import vreg_pkg::*;
#(
   parameter int NV = 8,
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   input  logic [NV-1:0]    end_strobe,
   output logic [NV-1:0]    kon_pulse,
   output logic [NV-1:0]    koff_pulse,
   output logic [NV-1:0]    endx,
   output logic [DW-1:0]    flg,
   output logic             mute
);
   logic          kon_hit, koff_hit, flg_hit, endf_hit;
   logic [NV-1:0] kon_now, koff_now, endx_nxt;

   always_comb begin
      kon_hit  = we && (idx == KON_IDX);
      koff_hit = we && (idx == KOFF_IDX);
      flg_hit  = we && (idx == FLG_IDX);
      endf_hit = we && (idx == ENDF_IDX);
      kon_now  = (kon_hit && !flg[FLG_SRST_BIT]) ? wdata[NV-1:0] : '0;
      koff_now = koff_hit ? wdata[NV-1:0] : '0;
      if (endf_hit) endx_nxt = '0;
      else          endx_nxt = (endx | end_strobe) & ~kon_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kon_pulse  <= '0;
         koff_pulse <= '0;
         endx       <= '0;
         flg        <= DW'(FLG_RST_VAL);
      end else begin
         kon_pulse  <= kon_now;
         koff_pulse <= koff_now;
         endx       <= endx_nxt;
         if (flg_hit) flg <= wdata;
      end
   end

   assign mute = flg[FLG_SRST_BIT] | flg[FLG_MUTE_BIT];
endmodule

// File: rtl/vreg_rmux.sv
module vreg_rmux
   import vreg_pkg::*;
#(
   parameter int NV = 8,
   parameter int DW = 8
) (
   input  vreg_cls_e        cls,
   input  logic [2:0]       voice,
   input  logic [DW-1:0]    bank_q,
   input  logic [NV*DW-1:0] env_level,
   input  logic [NV*DW-1:0] wave_level,
   input  logic [DW-1:0]    flg,
   input  logic [NV-1:0]    endx,
   output logic [DW-1:0]    rdata
);
   localparam int VSLOTS = 8;

   logic [DW-1:0] env_a  [VSLOTS];
   logic [DW-1:0] wave_a [VSLOTS];

   for (genvar v = 0; v < VSLOTS; v++) begin : g_slot
      if (v < NV) begin : g_live
         assign env_a[v]  = env_level[v*DW +: DW];
         assign wave_a[v] = wave_level[v*DW +: DW];
      end else begin : g_absent
         assign env_a[v]  = '0;
         assign wave_a[v] = '0;
      end
   end

   always_comb begin
      unique case (cls)
         CLS_ENV:  rdata = env_a[voice];
         CLS_WAVE: rdata = wave_a[voice];
         CLS_FLAG: rdata = flg;
         CLS_ENDF: rdata = DW'(endx);
         default:  rdata = bank_q;
      endcase
   end
endmodule

// File: rtl/vreg_port.sv
module vreg_port
   import vreg_pkg::*;
#(
   parameter int NUM_VOICES = 8,
   parameter int DATA_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_we,
   input  logic [7:0]                 sel_data,
   input  logic                       dat_we,
   input  logic [DATA_W-1:0]          dat_wdata,
   output logic [DATA_W-1:0]          dat_rdata,
   input  logic [NUM_VOICES*DATA_W-1:0] env_level,
   input  logic [NUM_VOICES*DATA_W-1:0] wave_level,
   input  logic [NUM_VOICES-1:0]      end_strobe,
   output logic [NUM_VOICES-1:0]      kon_pulse,
   output logic [NUM_VOICES-1:0]      koff_pulse,
   output logic                       mute_all
);
   if (NUM_VOICES < 1 || NUM_VOICES > 8) begin : g_bad_nv
      $error("vreg_port: NUM_VOICES must be 1..8");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("vreg_port: DATA_W must be at least 8");
   end

   logic [IDX_W-1:0]      cur_idx;
   vreg_cls_e             cur_cls;
   logic [DATA_W-1:0]     bank_q;
   logic [DATA_W-1:0]     flg_q;
   logic [NUM_VOICES-1:0] endx_q;
   logic                  bank_we;

   vreg_idx_latch #(.IN_W(8)) idx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sel_we),
      .din   (sel_data),
      .idx   (cur_idx)
   );

   assign cur_cls = vreg_classify(cur_idx);
   assign bank_we = dat_we && (cur_cls == CLS_PLAIN);

   vreg_bank #(.DW(DATA_W)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .idx   (cur_idx),
      .wdata (dat_wdata),
      .rdata (bank_q)
   );

   vreg_side #(.NV(NUM_VOICES), .DW(DATA_W)) side_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (dat_we),
      .idx        (cur_idx),
      .wdata      (dat_wdata),
      .end_strobe (end_strobe),
      .kon_pulse  (kon_pulse),
      .koff_pulse (koff_pulse),
      .endx       (endx_q),
      .flg        (flg_q),
      .mute       (mute_all)
   );

   vreg_rmux #(.NV(NUM_VOICES), .DW(DATA_W)) rmux_i (
      .cls        (cur_cls),
      .voice      (cur_idx[6:4]),
      .bank_q     (bank_q),
      .env_level  (env_level),
      .wave_level (wave_level),
      .flg        (flg_q),
      .endx       (endx_q),
      .rdata      (dat_rdata)
   );
endmodule

// File: rtl/vreg_port_chk.sv
module vreg_port_chk
   import vreg_pkg::*;
#(
   parameter int NV = 8,
   parameter int DW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_we,
   input logic [7:0]       sel_data,
   input logic             dat_we,
   input logic [DW-1:0]    dat_wdata,
   input logic [IDX_W-1:0] cur_idx,
   input logic [NV-1:0]    end_strobe,
   input logic [NV-1:0]    endx,
   input logic [DW-1:0]    flg,
   input logic [NV-1:0]    kon_pulse,
   input logic [NV-1:0]    koff_pulse,
   input logic             mute_all
);
   logic wr_kon, wr_koff, wr_flg, wr_endf;
   assign wr_kon  = dat_we && (cur_idx == KON_IDX);
   assign wr_koff = dat_we && (cur_idx == KOFF_IDX);
   assign wr_flg  = dat_we && (cur_idx == FLG_IDX);
   assign wr_endf = dat_we && (cur_idx == ENDF_IDX);

   assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> cur_idx == $past(sel_data[6:0]));

   assert_kon_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kon && flg[FLG_SRST_BIT]) |=> kon_pulse == '0);

   assert_kon_only_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_kon |=> kon_pulse == '0);

   assert_koff_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_koff |=> koff_pulse == $past(dat_wdata[NV-1:0]));

   assert_endf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_endf && !wr_kon) |=> (endx & $past(endx)) == $past(endx));

   assert_strobe_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_endf && !wr_kon) |=> (endx & $past(end_strobe)) == $past(end_strobe));

   assert_endf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_endf |=> endx == '0);

   assert_kon_clears_endf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kon |=> (endx & kon_pulse) == '0);

   assert_mute_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flg |=> mute_all == ($past(dat_wdata[FLG_SRST_BIT]) | $past(dat_wdata[FLG_MUTE_BIT])));
endmodule

bind vreg_port vreg_port_chk #(.NV(NUM_VOICES), .DW(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_we     (sel_we),
   .sel_data   (sel_data),
   .dat_we     (dat_we),
   .dat_wdata  (dat_wdata),
   .cur_idx    (cur_idx),
   .end_strobe (end_strobe),
   .endx       (endx_q),
   .flg        (flg_q),
   .kon_pulse  (kon_pulse),
   .koff_pulse (koff_pulse),
   .mute_all   (mute_all)
);

// File: tb/vreg_port_tb_top.sv
`timescale 1ns/1ps
module vreg_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_we = 1'b0;
   logic [7:0]  sel_data = '0;
   logic        dat_we = 1'b0;
   logic [7:0]  dat_wdata = '0;
   logic [7:0]  dat_rdata;
   logic [63:0] env_level = '0;
   logic [63:0] wave_level = '0;
   logic [7:0]  end_strobe = '0;
   logic [7:0]  kon_pulse, koff_pulse;
   logic        mute_all;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   vreg_port dut_i (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_data(sel_data),
      .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
      .env_level(env_level), .wave_level(wave_level), .end_strobe(end_strobe),
      .kon_pulse(kon_pulse), .koff_pulse(koff_pulse), .mute_all(mute_all)
   );

   // behavioural reference
   logic [7:0] m_mem [128];
   logic [6:0] m_idx;
   logic [7:0] m_endf, m_kon, m_koff;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
         m_mem[7'h6C] = 8'hE0;
         m_idx = '0; m_endf = '0; m_kon = '0; m_koff = '0;
      end else begin
         logic [7:0] kon_n, koff_n;
         logic       clr;
         kon_n = 8'h00; koff_n = 8'h00; clr = 1'b0;
         if (dat_we) begin
            if (m_idx == 7'h4C && !m_mem[7'h6C][7]) kon_n = dat_wdata;
            if (m_idx == 7'h5C) koff_n = dat_wdata;
            if (m_idx == 7'h7C) clr = 1'b1;
            if (m_idx[3:0] != 4'h8 && m_idx[3:0] != 4'h9 && m_idx != 7'h7C)
               m_mem[m_idx] = dat_wdata;
         end
         if (clr) m_endf = 8'h00;
         else     m_endf = (m_endf | end_strobe) & ~kon_n;
         m_kon = kon_n; m_koff = koff_n;
         if (sel_we) m_idx = sel_data[6:0];
      end
   end

   function automatic logic [7:0] m_read();
      if (m_idx[3:0] == 4'h8) return env_level[m_idx[6:4]*8 +: 8];
      if (m_idx[3:0] == 4'h9) return wave_level[m_idx[6:4]*8 +: 8];
      if (m_idx == 7'h7C)     return m_endf;
      return m_mem[m_idx];
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1 model rdata", dat_rdata, m_read());
         chk("R3 model kon", kon_pulse, m_kon);
         chk("R4 model koff", koff_pulse, m_koff);
         chk("R8 model mute", {7'b0, mute_all}, {7'b0, m_mem[7'h6C][7] | m_mem[7'h6C][6]});
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic set_idx(input logic [7:0] a);
      sel_we = 1'b1; sel_data = a; tick(); sel_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] d);
      dat_we = 1'b1; dat_wdata = d; tick(); dat_we = 1'b0;
   endtask

   task automatic wr_strobe(input logic [7:0] d, input logic [7:0] s);
      dat_we = 1'b1; dat_wdata = d; end_strobe = s; tick();
      dat_we = 1'b0; end_strobe = '0;
   endtask

   task automatic strobe(input logic [7:0] s);
      end_strobe = s; tick(); end_strobe = '0;
   endtask

   task automatic look(input string tag, input logic [7:0] act_sel, input logic [7:0] exp);
      @(negedge clk);
      case (act_sel)
         8'd0: chk(tag, dat_rdata, exp);
         8'd1: chk(tag, kon_pulse, exp);
         8'd2: chk(tag, koff_pulse, exp);
         default: chk(tag, {7'b0, mute_all}, exp);
      endcase
      tick();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int v = 0; v < 8; v++) begin
         env_level[v*8 +: 8]  = 8'h10 + 8'(v);
         wave_level[v*8 +: 8] = 8'hF0 - 8'(v);
      end
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2 reset state
      look("R2 mute after reset", 8'd3, 8'h01);
      look("R2 index 0 reads zero", 8'd0, 8'h00);
      set_idx(8'h6C); look("R2 flag reset value", 8'd0, 8'hE0);
      set_idx(8'h7C); look("R2 end flags zero", 8'd0, 8'h00);
      look("R2 kon idle", 8'd1, 8'h00);

      // R1 index latch, bit 7 ignored
      set_idx(8'h92); wr(8'h5A);
      set_idx(8'h12); look("R1 readback via masked index", 8'd0, 8'h5A);
      set_idx(8'h3D); wr(8'hC3); look("R1 readback global", 8'd0, 8'hC3);

      // R8 mute
      set_idx(8'h6C); wr(8'h00); look("R8 mute clear", 8'd3, 8'h00);
      wr(8'h40); look("R8 mute bit", 8'd3, 8'h01);
      wr(8'h80); look("R8 reset bit mutes", 8'd3, 8'h01);
      wr(8'h1F); look("R8 noise bits only", 8'd3, 8'h00);

      // R3 gating and pulse
      wr(8'h80); set_idx(8'h4C); wr(8'hFF);
      look("R3 kon suppressed", 8'd1, 8'h00);
      set_idx(8'h6C); wr(8'h00); set_idx(8'h4C); wr(8'hA5);
      look("R3 kon pulse", 8'd1, 8'hA5);
      look("R3 kon one cycle", 8'd1, 8'h00);

      // R4 key-off, also under soft reset
      set_idx(8'h5C); wr(8'h3C); look("R4 koff pulse", 8'd2, 8'h3C);
      look("R4 koff one cycle", 8'd2, 8'h00);
      set_idx(8'h6C); wr(8'h80); set_idx(8'h5C); wr(8'h81);
      look("R4 koff not gated", 8'd2, 8'h81);
      set_idx(8'h6C); wr(8'h00);

      // R5 sticky end flags
      set_idx(8'h7C); strobe(8'h81); look("R5 strobe sets", 8'd0, 8'h81);
      strobe(8'h02); look("R5 sticky accumulate", 8'd0, 8'h83);

      // R6 write clears, beats strobe
      wr_strobe(8'h55, 8'h10); look("R6 clear wins", 8'd0, 8'h00);

      // R7 key-on clears per voice
      strobe(8'h0F);
      set_idx(8'h4C); wr_strobe(8'h03, 8'h05);
      set_idx(8'h7C); look("R7 kon clears flags", 8'd0, 8'h0C);
      set_idx(8'h6C); wr(8'h80); set_idx(8'h4C); wr(8'h04);
      set_idx(8'h7C); look("R7 suppressed kon keeps flags", 8'd0, 8'h0C);
      set_idx(8'h6C); wr(8'h00);

      // R9 read-only voice views
      set_idx(8'h38); look("R9 envelope view", 8'd0, 8'h13);
      wr(8'h77); look("R9 envelope write ignored", 8'd0, 8'h13);
      set_idx(8'h59); look("R9 sample view", 8'd0, 8'hEB);

      // R10 select and data write together
      set_idx(8'h20);
      sel_we = 1'b1; sel_data = 8'h21; dat_we = 1'b1; dat_wdata = 8'h99; tick();
      sel_we = 1'b0; dat_we = 1'b0;
      look("R10 new index untouched", 8'd0, 8'h00);
      set_idx(8'h20); look("R10 old index written", 8'd0, 8'h99);

      // random mix, model compared every clock
      for (int n = 0; n < 4000; n++) begin
         sel_we = ($urandom_range(0, 3) == 0);
         case ($urandom_range(0, 6))
            0: sel_data = 8'h4C;
            1: sel_data = 8'h5C;
            2: sel_data = 8'h6C;
            3: sel_data = 8'h7C;
            default: sel_data = 8'($urandom_range(0, 255));
         endcase
         dat_we = ($urandom_range(0, 2) == 0);
         dat_wdata = 8'($urandom_range(0, 255));
         end_strobe = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
         if (n % 16 == 0) begin
            env_level  = {$urandom(), $urandom()};
            wave_level = {$urandom(), $urandom()};
         end
         tick();
      end
      sel_we = 1'b0; dat_we = 1'b0; end_strobe = '0;
      tick(); tick();
      summary();
      $finish;
   end
endmodule